// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block keeps a free-running 64-bit cycle counter and a comparison register for the processor's control coprocessor. It also raises a timer interrupt-pending flag when the low 32 bits of the counter reach the comparison value. The counter moves at half the pipeline clock rate. A two-state phase machine advances on every clock: state PH_EVEN moves to PH_ODD on the transition GO_ODD, and PH_ODD moves back to PH_EVEN on the transition GO_EVEN. The counter steps by one only on a clock edge taken while the machine is in PH_ODD.

Software reaches both registers through one write port: a select bit, a 64-bit data word and a write strobe. Writing the comparison register acknowledges the timer interrupt. The block also merges the 8-bit interrupt-pending vector with the status mask and the enable/exception-level bits, and gives the core a single pending-interrupt flag. The vector is made of the timer flag, five external lines and two software bits.

Top module: `timer_irq_unit`

## Requirements
- R1: While reset is asserted, count_q, compare_q and timer_ip are zero and the phase machine is in PH_EVEN.
- R2: With no write, count_q increases by exactly one on every second rising clock edge. The first increment happens on the second edge after reset is released.
- R3: A write with wr_sel = 0 loads wr_data into count_q on that edge. It replaces the increment of that edge and does not change the phase machine.
- R4: A write with wr_sel = 1 loads wr_data into compare_q on that edge. The counter keeps stepping as usual.
- R5: timer_ip becomes 1 on an incrementing edge when bits 31:0 of the incremented count equal bits 31:0 of compare_q. Bits 63:32 of both registers are ignored.
- R6: Once set, timer_ip stays 1 while the count moves past the match value, until compare_q is written.
- R7: Any write to compare_q clears timer_ip. This clear wins over a match on the same edge.
- R8: irq_pending is 1 exactly when st_ie = 1, st_exl = 0, st_erl = 0 and (st_im & ip) is nonzero, where ip = {timer_ip, ext_ip[4:0], sw_ip[1:0]}, so the timer is bit 7, external lines are bits 6:2 and software bits are 1:0. The result is combinational.
- R9: Loading count_q with a value that equals compare_q does not set timer_ip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 compare |
| wr_data | input | 64 | Write data |
| st_ie | input | 1 | Global interrupt enable |
| st_exl | input | 1 | Exception level active |
| st_erl | input | 1 | Error level active |
| st_im | input | 8 | Interrupt mask, one bit per pending bit |
| sw_ip | input | 2 | Software interrupt-pending bits |
| ext_ip | input | 5 | External interrupt lines |
| count_q | output | 64 | Current counter value |
| compare_q | output | 64 | Current comparison value |
| timer_ip | output | 1 | Timer interrupt-pending flag |
| irq_pending | output | 1 | Combined pending-interrupt flag for the core |

## Verification
The phase machine is hidden, but if it is in the wrong state, count_q steps on even edges instead of odd ones. That is visible at the port within two clocks of reset release or of any write, because the counter moves on the wrong edge. If timer_ip is set too early or too late, irq_pending shows the error on the same cycle whenever mask bit 7 and the enables are set. A lost acknowledge shows as timer_ip still set one cycle after a compare write. Directed cases place a compare write on the very edge of a match, and random stimulus keeps compare values close to the running count so that matches happen often.

// File: rtl/timer_irq_pkg.sv
package timer_irq_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    typedef enum logic {
        SEL_COUNT   = 1'b0,
        SEL_COMPARE = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/tick_phase_fsm.sv
module tick_phase_fsm
    import timer_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    phase_e state_q;
    phase_e state_d;

    // next-state selection: GO_ODD from PH_EVEN, GO_EVEN from PH_ODD
    always_comb begin
        unique case (state_q)
            PH_EVEN: state_d = PH_ODD;
            PH_ODD:  state_d = PH_EVEN;
            default: state_d = PH_EVEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_EVEN;
        end else begin
            state_q <= state_d;
        end
    end

    // output decode: counter steps on edges taken in PH_ODD
    always_comb begin
        unique case (state_q)
            PH_EVEN: tick = 1'b0;
            PH_ODD:  tick = 1'b1;
            default: tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/count_compare_regs.sv
module count_compare_regs
    import timer_irq_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int MATCH_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] compare_q,
    output logic             timer_ip
);

    logic             cnt_wr;
    logic             cmp_wr;
    logic [CNT_W-1:0] count_inc;
    logic             hit;

    always_comb begin
        cnt_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
        cmp_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_COMPARE);
        count_inc = count_q + CNT_W'(1);
        hit       = tick && !cnt_wr &&
                    (count_inc[MATCH_W-1:0] == compare_q[MATCH_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            compare_q <= '0;
            timer_ip  <= 1'b0;
        end else begin
            if (cnt_wr) begin
                count_q <= wr_data;
            end else if (tick) begin
                count_q <= count_inc;
            end
            if (cmp_wr) begin
                compare_q <= wr_data;
                timer_ip  <= 1'b0;
            end else if (hit) begin
                timer_ip  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int SW_W  = 2,
    parameter int EXT_W = 5,
    parameter int IP_W  = SW_W + EXT_W + 1
) (
    input  logic            st_ie,
    input  logic            st_exl,
    input  logic            st_erl,
    input  logic [IP_W-1:0] st_im,
    input  logic [SW_W-1:0] sw_ip,
    input  logic [EXT_W-1:0] ext_ip,
    input  logic            timer_ip,
    output logic            irq_pending
);

    logic [IP_W-1:0] ip_vec;

    always_comb begin
        ip_vec      = {timer_ip, ext_ip, sw_ip};
        irq_pending = st_ie && !st_exl && !st_erl && (|(st_im & ip_vec));
    end

endmodule

// File: rtl/timer_irq_unit.sv
module timer_irq_unit #(
    parameter int CNT_W   = 64,
    parameter int MATCH_W = 32,
    parameter int SW_W    = 2,
    parameter int EXT_W   = 5,
    localparam int IP_W   = SW_W + EXT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             st_ie,
    input  logic             st_exl,
    input  logic             st_erl,
    input  logic [IP_W-1:0]  st_im,
    input  logic [SW_W-1:0]  sw_ip,
    input  logic [EXT_W-1:0] ext_ip,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] compare_q,
    output logic             timer_ip,
    output logic             irq_pending
);

    logic tick;

    tick_phase_fsm u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    count_compare_regs #(
        .CNT_W   (CNT_W),
        .MATCH_W (MATCH_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .count_q   (count_q),
        .compare_q (compare_q),
        .timer_ip  (timer_ip)
    );

    irq_combine #(
        .SW_W  (SW_W),
        .EXT_W (EXT_W),
        .IP_W  (IP_W)
    ) u_comb (
        .st_ie       (st_ie),
        .st_exl      (st_exl),
        .st_erl      (st_erl),
        .st_im       (st_im),
        .sw_ip       (sw_ip),
        .ext_ip      (ext_ip),
        .timer_ip    (timer_ip),
        .irq_pending (irq_pending)
    );

endmodule

// File: rtl/timer_irq_checker.sv
module timer_irq_checker #(
    parameter int CNT_W   = 64,
    parameter int MATCH_W = 32,
    parameter int IP_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             st_ie,
    input logic             st_exl,
    input logic             st_erl,
    input logic [IP_W-1:0]  st_im,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] compare_q,
    input logic             timer_ip,
    input logic             irq_pending
);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (count_q == '0 && compare_q == '0 && !timer_ip)); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> (count_q - $past(count_q)) <= CNT_W'(1)); // R2

    AST_CNT_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n) (!wr_en && !$past(wr_en) && count_q != $past(count_q)) |=> count_q == $past(count_q)); // R2

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_sel) |=> count_q == $past(wr_data)); // R3

    AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel) |=> compare_q == $past(wr_data)); // R4

    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $rose(timer_ip) |-> count_q[MATCH_W-1:0] == compare_q[MATCH_W-1:0]); // R5

    AST_TIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (timer_ip && !(wr_en && wr_sel)) |=> timer_ip); // R6

    AST_CMP_ACK: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel) |=> !timer_ip); // R7

    AST_PEND_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (!st_ie || st_exl || st_erl || st_im == '0) |-> !irq_pending); // R8

    AST_LOAD_NO_SET: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_sel && !timer_ip) |=> !timer_ip); // R9

endmodule

bind timer_irq_unit timer_irq_checker #(
    .CNT_W   (CNT_W),
    .MATCH_W (MATCH_W),
    .IP_W    (IP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .st_ie       (st_ie),
    .st_exl      (st_exl),
    .st_erl      (st_erl),
    .st_im       (st_im),
    .count_q     (count_q),
    .compare_q   (compare_q),
    .timer_ip    (timer_ip),
    .irq_pending (irq_pending)
);

// File: tb/test_timer_irq_unit.sv
`timescale 1ns/1ps
module test_timer_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [63:0] wr_data = '0;
    logic        st_ie = 1'b0;
    logic        st_exl = 1'b0;
    logic        st_erl = 1'b0;
    logic [7:0]  st_im = '0;
    logic [1:0]  sw_ip = '0;
    logic [4:0]  ext_ip = '0;
    logic [63:0] count_q;
    logic [63:0] compare_q;
    logic        timer_ip;
    logic        irq_pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state kept from the requirements
    logic [63:0] m_cnt = '0;
    logic [63:0] m_cmp = '0;
    logic        m_tip = 1'b0;
    logic        m_odd = 1'b0;

    always #5 clk = ~clk;

    timer_irq_unit i_timer_irq_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .st_ie(st_ie), .st_exl(st_exl), .st_erl(st_erl), .st_im(st_im),
        .sw_ip(sw_ip), .ext_ip(ext_ip), .count_q(count_q), .compare_q(compare_q),
        .timer_ip(timer_ip), .irq_pending(irq_pending)
    );

    function automatic logic exp_pending(logic tip);
        logic [7:0] ip;
        ip = {tip, ext_ip, sw_ip};
        return st_ie && !st_exl && !st_erl && (|(st_im & ip));
    endfunction

    function automatic logic exp_hit(logic [63:0] cnt, logic [63:0] cmp);
        logic [63:0] nxt;
        nxt = cnt + 64'd1;
        return nxt[31:0] == cmp[31:0];
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: model the edge, then check away from it
    task automatic tick();
        logic cw;
        logic kw;
        logic was_tip;
        cw = wr_en && wr_sel;
        kw = wr_en && !wr_sel;
        @(posedge clk);
        was_tip = m_tip;
        if (cw) m_tip = 1'b0;
        else if (m_odd && !kw && exp_hit(m_cnt, m_cmp)) m_tip = 1'b1;
        if (kw) m_cnt = wr_data;
        else if (m_odd) m_cnt = m_cnt + 64'd1;
        if (cw) m_cmp = wr_data;
        m_odd = !m_odd;
        @(negedge clk);
        chk(kw ? "R3" : "R2", count_q, m_cnt);
        chk("R4", compare_q, m_cmp);
        if (cw) chk("R7", {63'd0, timer_ip}, {63'd0, m_tip});
        else if (kw) chk("R9", {63'd0, timer_ip}, {63'd0, m_tip});
        else if (m_tip && !was_tip) chk("R5", {63'd0, timer_ip}, {63'd0, m_tip});
        else chk("R6", {63'd0, timer_ip}, {63'd0, m_tip});
        chk("R8", {63'd0, irq_pending}, {63'd0, exp_pending(m_tip)});
        wr_en = 1'b0;
    endtask

    task automatic wr(logic sel, logic [63:0] d);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = d;
        tick();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357_2468));
        repeat (3) @(negedge clk);
        chk("R1", count_q, 64'd0);
        chk("R1", compare_q, 64'd0);
        chk("R1", {63'd0, timer_ip}, 64'd0);
        rst_n = 1'b1;

        // R2: free running at half rate
        st_ie = 1'b1; st_im = 8'h80;
        repeat (6) tick();

        // R3: count load keeps phase
        wr(1'b0, 64'h0000_0001_FFFF_FFF0);
        repeat (3) tick();

        // R5: match on low half only, upper half differs
        wr(1'b1, {32'hABCD_0123, m_cnt[31:0] + 32'd3});
        repeat (8) tick();
        // R6: still set after passing match
        repeat (4) tick();
        // R8: masking gates the pending flag
        st_exl = 1'b1; tick(); st_exl = 1'b0;
        st_erl = 1'b1; tick(); st_erl = 1'b0;
        st_ie = 1'b0;  tick(); st_ie = 1'b1;
        // R7: acknowledge
        wr(1'b1, 64'hFFFF_FFFF_0000_0000);
        tick();

        // R9: load count equal to compare
        wr(1'b0, m_cmp);
        repeat (4) tick();

        // R7: compare write on the matching edge
        if (m_odd) tick();
        wr(1'b1, m_cnt + 64'd1);
        wr(1'b1, 64'h0000_0000_1234_5678);
        tick();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            st_ie  = r[0] | r[1];
            st_exl = (r[4:2] == 3'd0);
            st_erl = (r[7:5] == 3'd0);
            st_im  = r[15:8];
            sw_ip  = r[17:16] & {2{r[18]}};
            ext_ip = r[23:19] & {5{r[24]}};
            if (r[28:25] == 4'd0) begin
                wr_en = 1'b1;
                wr_sel = r[29];
                wr_data = r[29] ? (m_cnt + 64'($urandom_range(0, 12)))
                                : {$urandom, $urandom};
            end
            tick();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule